// File: doc/BRIEF.md
# USB OUT Endpoint Receive Controller

This block holds the receive-side state of a few USB device endpoints and chooses the handshake for each OUT or SETUP data packet. Each endpoint has an eight-bit register with four parts: a control flag, the expected data toggle, a two-bit receive status and a four-bit endpoint address. A decoded token picks the endpoint whose address field matches the token's endpoint number. The data packet that follows is then answered with ACK, NAK, STALL or no handshake, based on that endpoint's status, the packet's CRC result and its data PID.

After a correct transfer, the block pulses a correct-transfer flag that carries the endpoint index. It also locks the endpoint to NAK, so that firmware has time to drain the buffer before it writes VALID again. A SETUP token aimed at a control endpoint clears that endpoint's toggle, because SETUP data always travels as DATA0. Endpoint 0 is permanently a control endpoint with address 0. Serial decoding, CRC computation and buffering are handled elsewhere.

Top module: `usb_rx_ep_ctrl`

## Requirements
- R1: Endpoint register layout: bit 7 is the control flag, bit 6 is the expected toggle (0 = DATA0, 1 = DATA1), bits 5:4 are the status (00 disabled, 01 stall, 10 NAK, 11 valid) and bits 3:0 are the address. The handshake code is 0 none, 1 ACK, 2 NAK, 3 STALL.
- R2: The handshake code and the correct-transfer flag are registered. They appear in the cycle after the data packet strobe, last one cycle, and are none or 0 at all other times.
- R3: For a good packet on a matched endpoint, a stall status answers STALL, a NAK status answers NAK, and a disabled status gives no handshake. None of these changes the register.
- R4: On a valid endpoint, a good packet whose PID equals the expected toggle is answered with ACK. It also raises the correct-transfer flag with that endpoint's index, inverts the toggle and sets the status to NAK.
- R5: On a valid endpoint, a good packet whose PID differs from the toggle is answered with ACK. It raises no correct-transfer flag and leaves toggle and status unchanged.
- R6: A packet with a bad CRC, or one following a token whose number matches no address field, gives no handshake and changes no register.
- R7: A SETUP token to an endpoint with the control flag set clears its toggle at the token. A SETUP token to an endpoint without the flag is ignored, and its packet gives no handshake.
- R8: A token is steered to the endpoint whose address field equals the token number. If several match, the lowest index wins.
- R9: Endpoint 0 reads 0x80 after reset. Its bit 7 always reads 1 and its bits 3:0 always read 0, whatever software writes. Other endpoints reset to 0x00.
- R10: A USB bus reset returns every endpoint register to its reset value.
- R11: If a software write and a hardware update hit the same endpoint in the same cycle, the hardware update is applied and the software write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_reset | input | 1 | USB bus reset, synchronous |
| tok_valid | input | 1 | Decoded OUT/SETUP token strobe |
| tok_setup | input | 1 | 1 = SETUP token, 0 = OUT token |
| tok_ep | input | 4 | Token endpoint number |
| pkt_valid | input | 1 | End-of-data-packet strobe |
| pkt_pid1 | input | 1 | Packet PID: 1 = DATA1, 0 = DATA0 |
| pkt_crc_ok | input | 1 | Packet CRC was good |
| sw_wr | input | 1 | Software register write strobe |
| sw_idx | input | IDX_W | Endpoint index for read and write |
| sw_wdata | input | 8 | Write data |
| sw_rdata | output | 8 | Read data of endpoint sw_idx |
| hs_code | output | 2 | Handshake to send |
| ctr_valid | output | 1 | Correct transfer pulse |
| ctr_ep | output | IDX_W | Endpoint index of the correct transfer |

## Verification
The bench uses the default of three endpoints, so the index is two bits wide. This lets it steer traffic to endpoint 0 and to both non-zero endpoints, and it makes the hardware-fixed bits of endpoint 0 visible next to ordinary registers. With three endpoints the bench can also give two registers the same address to show that the lower index wins. The same setup shows a bus reset clearing a register that software had set.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;

  typedef enum logic [1:0] {
    ST_DIS   = 2'b00,
    ST_STALL = 2'b01,
    ST_NAK   = 2'b10,
    ST_VALID = 2'b11
  } rx_stat_e;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_e;

  typedef struct packed {
    logic     ctrl;
    logic     tog;
    rx_stat_e stat;
    logic [3:0] addr;
  } ep_reg_t;

  // Handshake implied by a status for a good packet on a matched endpoint.
  function automatic hs_e stat_to_hs(rx_stat_e s);
    case (s)
      ST_VALID: return HS_ACK;
      ST_NAK:   return HS_NAK;
      ST_STALL: return HS_STALL;
      default:  return HS_NONE;
    endcase
  endfunction

  // A transfer is accepted when the endpoint is valid and the PID matches.
  function automatic logic is_good_xfer(rx_stat_e s, logic tog, logic pid1);
    return (s == ST_VALID) && (tog == pid1);
  endfunction

endpackage

// File: rtl/usb_rx_ep_reg.sv
module usb_rx_ep_reg
  import usb_rx_pkg::*;
#(
  parameter bit IS_EP0 = 1'b0
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    bus_reset,
  input  logic    sw_we,
  input  ep_reg_t sw_wdata,
  input  logic    hw_done,
  input  logic    hw_clr_tog,
  output ep_reg_t q
);

  function automatic ep_reg_t fix_bits(ep_reg_t d);
    ep_reg_t r;
    r = d;
    if (IS_EP0) begin
      r.ctrl = 1'b1;
      r.addr = 4'd0;
    end
    return r;
  endfunction

  localparam ep_reg_t RST_VAL = fix_bits(ep_reg_t'(8'h00));

  always_ff @(posedge clk) begin
    if (!rst_n || bus_reset) begin
      q <= RST_VAL;
    end else if (hw_done) begin
      q.tog  <= ~q.tog;
      q.stat <= ST_NAK;
    end else if (hw_clr_tog) begin
      q.tog <= 1'b0;
    end else if (sw_we) begin
      q <= fix_bits(sw_wdata);
    end
  end

  a_r4_done_locks_nak: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
    hw_done |=> (q.stat == ST_NAK) && (q.tog != $past(q.tog)));

  a_r7_setup_clears_tog: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
    (hw_clr_tog && !hw_done) |=> !q.tog);

  a_r11_sw_write_dropped: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
    (hw_done && sw_we) |=> (q.addr == $past(q.addr)) && (q.ctrl == $past(q.ctrl)));

endmodule

// File: rtl/usb_rx_ep_match.sv
module usb_rx_ep_match #(
  parameter int NUM_EP = 3,
  parameter int IDX_W  = 2
) (
  input  logic [3:0]              tok_ep,
  input  logic [NUM_EP-1:0][3:0]  addrs,
  output logic                    hit,
  output logic [IDX_W-1:0]        idx
);

  logic [NUM_EP-1:0] eq;

  for (genvar g = 0; g < NUM_EP; g++) begin : g_cmp
    assign eq[g] = (addrs[g] == tok_ep);
  end

  // Lowest matching index wins.
  always_comb begin
    hit = |eq;
    idx = '0;
    for (int i = NUM_EP - 1; i >= 0; i--) begin
      if (eq[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/usb_rx_hs_decide.sv
module usb_rx_hs_decide
  import usb_rx_pkg::*;
(
  input  logic    pkt_valid,
  input  logic    pkt_crc_ok,
  input  logic    pkt_pid1,
  input  logic    pend_hit,
  input  ep_reg_t cur,
  output hs_e     hs,
  output logic    good
);

  logic live;
  assign live = pkt_valid && pkt_crc_ok && pend_hit;

  always_comb begin
    hs   = live ? stat_to_hs(cur.stat) : HS_NONE;
    good = live && is_good_xfer(cur.stat, cur.tog, pkt_pid1);
  end

endmodule

// File: rtl/usb_rx_ep_ctrl.sv
module usb_rx_ep_ctrl
  import usb_rx_pkg::*;
#(
  parameter int NUM_EP = 3,
  localparam int IDX_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_reset,
  input  logic             tok_valid,
  input  logic             tok_setup,
  input  logic [3:0]       tok_ep,
  input  logic             pkt_valid,
  input  logic             pkt_pid1,
  input  logic             pkt_crc_ok,
  input  logic             sw_wr,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic [7:0]       sw_wdata,
  output logic [7:0]       sw_rdata,
  output logic [1:0]       hs_code,
  output logic             ctr_valid,
  output logic [IDX_W-1:0] ctr_ep
);

  ep_reg_t                 regs [NUM_EP];
  logic [NUM_EP-1:0][3:0]  addrs;
  logic [NUM_EP-1:0]       tog_vec;
  logic [NUM_EP-1:0]       stat_nak_vec;

  logic                    tok_hit;
  logic [IDX_W-1:0]        tok_idx;
  logic                    tok_ctrl;
  logic                    setup_clr;

  logic                    pend_hit_q;
  logic [IDX_W-1:0]        pend_idx_q;
  ep_reg_t                 cur;

  hs_e                     hs_next;
  logic                    good_xfer;

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    logic we_g, done_g, clr_g;
    assign we_g   = sw_wr && (sw_idx == IDX_W'(g));
    assign done_g = good_xfer && (pend_idx_q == IDX_W'(g));
    assign clr_g  = setup_clr && (tok_idx == IDX_W'(g));

    usb_rx_ep_reg #(.IS_EP0(g == 0)) u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_reset  (bus_reset),
      .sw_we      (we_g),
      .sw_wdata   (ep_reg_t'(sw_wdata)),
      .hw_done    (done_g),
      .hw_clr_tog (clr_g),
      .q          (regs[g])
    );

    assign addrs[g]        = regs[g].addr;
    assign tog_vec[g]      = regs[g].tog;
    assign stat_nak_vec[g] = (regs[g].stat == ST_NAK);
  end

  usb_rx_ep_match #(.NUM_EP(NUM_EP), .IDX_W(IDX_W)) u_match (
    .tok_ep (tok_ep),
    .addrs  (addrs),
    .hit    (tok_hit),
    .idx    (tok_idx)
  );

  always_comb begin
    tok_ctrl = 1'b0;
    cur      = ep_reg_t'(8'h00);
    sw_rdata = 8'h00;
    for (int i = 0; i < NUM_EP; i++) begin
      if (tok_idx == IDX_W'(i))    tok_ctrl = regs[i].ctrl;
      if (pend_idx_q == IDX_W'(i)) cur      = regs[i];
      if (sw_idx == IDX_W'(i))     sw_rdata = regs[i];
    end
  end

  assign setup_clr = tok_valid && tok_setup && tok_hit && tok_ctrl;

  // Pending token: which endpoint the next data packet belongs to.
  always_ff @(posedge clk) begin
    if (!rst_n || bus_reset) begin
      pend_hit_q <= 1'b0;
      pend_idx_q <= '0;
    end else if (tok_valid) begin
      pend_hit_q <= tok_hit && (!tok_setup || tok_ctrl);
      pend_idx_q <= tok_idx;
    end else if (pkt_valid) begin
      pend_hit_q <= 1'b0;
    end
  end

  usb_rx_hs_decide u_decide (
    .pkt_valid  (pkt_valid),
    .pkt_crc_ok (pkt_crc_ok),
    .pkt_pid1   (pkt_pid1),
    .pend_hit   (pend_hit_q),
    .cur        (cur),
    .hs         (hs_next),
    .good       (good_xfer)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || bus_reset) begin
      hs_code   <= HS_NONE;
      ctr_valid <= 1'b0;
      ctr_ep    <= '0;
    end else begin
      hs_code   <= hs_next;
      ctr_valid <= good_xfer;
      ctr_ep    <= good_xfer ? pend_idx_q : '0;
    end
  end

  a_r2_hs_follows_pkt: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
    (hs_code != HS_NONE) |-> $past(pkt_valid));

  a_r4_ctr_with_ack: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
    ctr_valid |-> (hs_code == HS_ACK));

  a_r4_ctr_ep_naks: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
    ctr_valid |-> stat_nak_vec[ctr_ep]);

  a_r5_mismatch_keeps_tog: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
    ((hs_code == HS_ACK) && !ctr_valid && !$past(sw_wr) && !$past(tok_valid))
      |-> (tog_vec == $past(tog_vec)));

  a_r6_bad_crc_silent: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
    (pkt_valid && !pkt_crc_ok) |=> (hs_code == HS_NONE) && !ctr_valid);

endmodule

// File: tb/usb_rx_ep_ctrl_bench.sv
module usb_rx_ep_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_EP     = 3;
  localparam int IW         = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_reset = 1'b0;
  logic tok_valid = 1'b0, tok_setup = 1'b0;
  logic [3:0] tok_ep = '0;
  logic pkt_valid = 1'b0, pkt_pid1 = 1'b0, pkt_crc_ok = 1'b0;
  logic sw_wr = 1'b0;
  logic [IW-1:0] sw_idx = '0;
  logic [7:0] sw_wdata = '0;
  logic [7:0] sw_rdata;
  logic [1:0] hs_code;
  logic ctr_valid;
  logic [IW-1:0] ctr_ep;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_rx_ep_ctrl #(.NUM_EP(NUM_EP)) u_usb_rx_ep_ctrl (
    .clk, .rst_n, .bus_reset, .tok_valid, .tok_setup, .tok_ep,
    .pkt_valid, .pkt_pid1, .pkt_crc_ok, .sw_wr, .sw_idx, .sw_wdata,
    .sw_rdata, .hs_code, .ctr_valid, .ctr_ep
  );

  // Handshake codes (R1): 0 none, 1 ACK, 2 NAK, 3 STALL.
  typedef struct packed {
    logic [7:0] init;
    logic       setup;
    logic [3:0] tep;
    logic       pid;
    logic       crc;
    logic [1:0] ehs;
    logic       ectr;
    logic [7:0] ereg;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{8'h31, 1'b0, 4'd1, 1'b0, 1'b1, 2'd1, 1'b1, 8'h61}, // R4 good OUT
    '{8'h71, 1'b0, 4'd1, 1'b0, 1'b1, 2'd1, 1'b0, 8'h71}, // R5 mismatch
    '{8'h71, 1'b0, 4'd1, 1'b1, 1'b1, 2'd1, 1'b1, 8'h21}, // R4 DATA1
    '{8'h31, 1'b0, 4'd1, 1'b0, 1'b0, 2'd0, 1'b0, 8'h31}, // R6 bad crc
    '{8'h21, 1'b0, 4'd1, 1'b0, 1'b1, 2'd2, 1'b0, 8'h21}, // R3 NAK
    '{8'h11, 1'b0, 4'd1, 1'b0, 1'b1, 2'd3, 1'b0, 8'h11}, // R3 STALL
    '{8'h01, 1'b0, 4'd1, 1'b0, 1'b1, 2'd0, 1'b0, 8'h01}, // R3 disabled
    '{8'h31, 1'b0, 4'd5, 1'b0, 1'b1, 2'd0, 1'b0, 8'h31}, // R6 no match
    '{8'h71, 1'b1, 4'd1, 1'b0, 1'b1, 2'd0, 1'b0, 8'h71}, // R7 setup non-ctrl
    '{8'hF1, 1'b1, 4'd1, 1'b0, 1'b1, 2'd1, 1'b1, 8'hE1}, // R7 setup clears
    '{8'hE1, 1'b1, 4'd1, 1'b0, 1'b1, 2'd2, 1'b0, 8'hA1}  // R7 clear on NAK ep
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [7:0] d);
    @(negedge clk);
    sw_wr = 1'b1; sw_idx = IW'(idx); sw_wdata = d;
    @(negedge clk);
    sw_wr = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [7:0] d);
    sw_idx = IW'(idx);
    #1;
    d = sw_rdata;
  endtask

  task automatic tok(input logic setup, input logic [3:0] ep);
    @(negedge clk);
    tok_valid = 1'b1; tok_setup = setup; tok_ep = ep;
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  task automatic pkt(input logic pid, input logic crc);
    @(negedge clk);
    pkt_valid = 1'b1; pkt_pid1 = pid; pkt_crc_ok = crc;
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset values, R2 idle outputs
    rd(0, r); chk("R9 ep0 reset", r, 8'h80);
    rd(1, r); chk("R9 ep1 reset", r, 8'h00);
    chk("R2 idle hs", hs_code, 2'd0);
    chk("R2 idle ctr", ctr_valid, 1'b0);

    // Table walk on endpoint 1 (R3..R7)
    for (int i = 0; i < NV; i++) begin
      wr(1, VECS[i].init);
      tok(VECS[i].setup, VECS[i].tep);
      pkt(VECS[i].pid, VECS[i].crc);
      chk($sformatf("R3-vec%0d hs", i), hs_code, VECS[i].ehs);
      chk($sformatf("R4-vec%0d ctr", i), ctr_valid, VECS[i].ectr);
      if (VECS[i].ectr) chk($sformatf("R4-vec%0d ctr_ep", i), ctr_ep, 1);
      rd(1, r); chk($sformatf("R5-vec%0d reg", i), r, VECS[i].ereg);
      @(negedge clk);
      chk($sformatf("R2-vec%0d hs one cycle", i), hs_code, 2'd0);
    end

    // R9 endpoint 0 fixed bits
    wr(0, 8'h3F);
    rd(0, r); chk("R9 ep0 forced bits", r, 8'hB0);
    tok(1'b0, 4'd0);
    pkt(1'b0, 1'b1);
    chk("R4 ep0 ack", hs_code, 2'd1);
    chk("R4 ep0 ctr", ctr_valid, 1'b1);
    chk("R4 ep0 ctr_ep", ctr_ep, 0);
    rd(0, r); chk("R4 ep0 reg", r, 8'hE0);

    // R8 lowest index wins: ep1 addr 0 valid, ep0 NAK
    wr(1, 8'h30);
    tok(1'b0, 4'd0);
    pkt(1'b0, 1'b1);
    chk("R8 lowest index hs", hs_code, 2'd2);
    rd(1, r); chk("R8 ep1 untouched", r, 8'h30);

    // R4 endpoint 2 index
    wr(2, 8'h32);
    tok(1'b0, 4'd2);
    pkt(1'b0, 1'b1);
    chk("R4 ep2 ctr", ctr_valid, 1'b1);
    chk("R4 ep2 ctr_ep", ctr_ep, 2);
    rd(2, r); chk("R4 ep2 reg", r, 8'h62);

    // R11 hardware update beats software write
    wr(1, 8'h31);
    tok(1'b0, 4'd1);
    @(negedge clk);
    pkt_valid = 1'b1; pkt_pid1 = 1'b0; pkt_crc_ok = 1'b1;
    sw_wr = 1'b1; sw_idx = IW'(1); sw_wdata = 8'h00;
    @(negedge clk);
    pkt_valid = 1'b0; sw_wr = 1'b0;
    chk("R11 hs ack", hs_code, 2'd1);
    rd(1, r); chk("R11 hw wins", r, 8'h61);

    // R10 bus reset
    wr(2, 8'h72);
    @(negedge clk);
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
    rd(0, r); chk("R10 ep0 after bus reset", r, 8'h80);
    rd(1, r); chk("R10 ep1 after bus reset", r, 8'h00);
    rd(2, r); chk("R10 ep2 after bus reset", r, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule